// File: doc/BRIEF.md
# Challenge-Response Mode Guard

This block keeps the operating mode of a chip and lets software move it between modes. Harmless moves back to Normal take a single register write. The critical moves need two commands. Normal to Interrupt, Normal to Flash and Normal to Reset are critical, and so is a return to Init from any other mode. The first command names the wanted mode. The block answers by latching an 8-bit challenge drawn from a free-running linear feedback shift register. Software reads the challenge, inverts every bit and writes the result back. The move happens only when that answer is correct.

Commands arrive from an SPI front end as one-cycle strobes. Each strobe carries a read/write flag, a 2-bit register address and an 8-bit write value. Read data comes back in a register one cycle after the strobe. The current mode is shown on a 3-bit output, and a one-cycle pulse marks every mode change. While the block is in Reset mode it counts a fixed number of cycles and then falls back to Init on its own.

Mode codes: Normal=0, Interrupt=1, Flash=2, Reset=3, Init=4. Register addresses: 0 holds the mode, 1 takes a request, 2 takes the answer and 3 holds the challenge.

Top module: `secmode_unlock`

## Requirements
- R1: After reset the mode output is 4 (Init) and `mode_chg` is low. `rd_data` reads 0, the mode register reads 8'h04 and the challenge register reads 0.
- R2: A write of 8'h00 to address 0 moves Init, Interrupt or Flash to Normal, with a one-cycle `mode_chg` pulse in the cycle after the strobe and any pending request dropped. A write of any other value, or a write made in Normal or Reset, leaves the mode unchanged.
- R3: A write to address 1 names a target mode in bits [2:0]: 1 Interrupt, 2 Flash, 3 Reset, 4 Init. Targets 1 to 3 are legal only from Normal, and target 4 is legal from every mode except Init. A legal request sets the pending flag and loads a new challenge. An illegal one leaves both the pending flag and the challenge unchanged.
- R4: A read of address 0 returns {pending, 4'b0, mode[2:0]}. A read of address 3 returns the challenge. A read changes neither the challenge, the pending flag nor the mode.
- R5: Each accepted request loads a challenge different from the one held before it.
- R6: While a request is pending, a write to address 2 with the bitwise inverse of the challenge moves to the requested mode. The move shows on the mode output with a `mode_chg` pulse in the cycle after the strobe, and the pending flag clears.
- R7: While a request is pending, a write to address 2 with any other value leaves the mode unchanged and cancels the request. A later correct answer has no effect until a new request is made.
- R8: A write to address 2 while no request is pending has no effect.
- R9: Reset mode lasts exactly RESET_HOLD cycles. The block then enters Init with a `mode_chg` pulse.
- R10: A challenge loaded by a request is never zero.
- R11: A new legal request made while another is pending replaces the target and the challenge. The inverse of the old challenge is then rejected as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 2 | Register address |
| cmd_wdata | input | 8 | Write value |
| rd_data | output | 8 | Read result, valid from the cycle after a read strobe until the next read |
| mode_o | output | 3 | Current mode code |
| mode_chg | output | 1 | High for one cycle after each mode change |

## Verification
The assertions assume that a strobe lasts one cycle, carries a single command, and that its write value is stable while it is high. The stimulus sets all command fields together on the falling edge and drops the strobe on the next falling edge. The bench issues no command while the mode is Reset, so the countdown to Init runs without interference. Random requests, answers (correct and corrupted), plain writes and reads are drawn from a seeded generator and mixed with directed sequences. Every answer is built from a challenge that the bench first reads back through address 3.

// File: rtl/secmode_pkg.sv
package secmode_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] A_REQ  = 2'd1;
    localparam logic [ADDR_W-1:0] A_KEY  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CODE = 2'd3;

    typedef enum logic [2:0] {
        M_NORMAL = 3'd0,
        M_INTR   = 3'd1,
        M_FLASH  = 3'd2,
        M_RESET  = 3'd3,
        M_INIT   = 3'd4
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic  grant;
        mode_e target;
    } grant_t;

    function automatic logic req_legal(input mode_e cur, input logic [2:0] tgt);
        logic ok;
        case (tgt)
            3'd1, 3'd2, 3'd3: ok = (cur == M_NORMAL);
            3'd4:             ok = (cur != M_INIT);
            default:          ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic is_wr(input cmd_t c, input logic [ADDR_W-1:0] a);
        return c.valid && c.write && (c.addr == a);
    endfunction

endpackage

// File: rtl/secmode_lfsr.sv
module secmode_lfsr
    import secmode_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 8'h5A,
    parameter logic [DATA_W-1:0] TAPS = 8'hB8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] state,
    output logic [DATA_W-1:0] state_nxt
);

    // Galois form, shifting right; the feedback mask is applied when bit 0 is set
    always_comb begin
        state_nxt = state >> 1;
        if (state[0]) state_nxt = state_nxt ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= state_nxt;
    end

    // R10: the source never falls into the all-zero lock-up state
    a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/secmode_challenge.sv
module secmode_challenge
    import secmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  mode_e             cur_mode,
    input  logic              mode_changing,
    input  logic [DATA_W-1:0] rnd_now,
    input  logic [DATA_W-1:0] rnd_nxt,
    output logic [DATA_W-1:0] code,
    output logic              pending,
    output grant_t            grant
);

    mode_e             tgt_q;
    logic              req_hit;
    logic              key_hit;
    logic [DATA_W-1:0] fresh;

    assign req_hit = is_wr(cmd, A_REQ) && req_legal(cur_mode, cmd.data[2:0]) && !mode_changing;
    assign key_hit = is_wr(cmd, A_KEY) && pending;
    // never hand out the same challenge twice in a row
    assign fresh   = (rnd_now == code) ? rnd_nxt : rnd_now;

    always_comb begin
        grant.grant  = key_hit && (cmd.data == ~code);
        grant.target = tgt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            code    <= '0;
            tgt_q   <= M_INIT;
        end else if (req_hit) begin
            pending <= 1'b1;
            code    <= fresh;
            tgt_q   <= mode_e'(cmd.data[2:0]);
        end else if (key_hit || mode_changing) begin
            pending <= 1'b0;
        end
    end

    a_r10_code_nonzero: assert property (@(posedge clk) disable iff (rst)
        pending |-> code != '0);

    a_r5_code_fresh: assert property (@(posedge clk) disable iff (rst)
        req_hit |=> code != $past(code));

    a_r7_wrong_key_cancels: assert property (@(posedge clk) disable iff (rst)
        (key_hit && cmd.data != ~code) |=> !pending);

    a_r4_read_keeps_code: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && !cmd.write) |=> $stable(code));

endmodule

// File: rtl/secmode_fsm.sv
module secmode_fsm
    import secmode_pkg::*;
#(
    parameter int RESET_HOLD = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  cmd_t   cmd,
    input  grant_t grant,
    output mode_e  mode,
    output logic   mode_chg,
    output logic   changing
);

    localparam int CNT_W = $clog2(RESET_HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESET_HOLD - 1);

    logic [CNT_W-1:0] cnt;
    mode_e            nxt;
    logic             plain_ok;

    assign plain_ok = is_wr(cmd, A_MODE) && (cmd.data == '0) &&
                      (mode == M_INIT || mode == M_INTR || mode == M_FLASH);

    always_comb begin
        nxt = mode;
        if (grant.grant)                            nxt = grant.target;
        else if (plain_ok)                          nxt = M_NORMAL;
        else if (mode == M_RESET && cnt == CNT_LAST) nxt = M_INIT;
    end

    assign changing = (nxt != mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= M_INIT;
            mode_chg <= 1'b0;
            cnt      <= '0;
        end else begin
            mode     <= nxt;
            mode_chg <= changing;
            cnt      <= (mode == M_RESET && nxt == M_RESET) ? cnt + 1'b1 : '0;
        end
    end

    a_r6_pulse_marks_change: assert property (@(posedge clk) disable iff (rst)
        mode_chg |-> mode != $past(mode));

    a_r3_critical_from_normal: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode) && (mode == M_INTR || mode == M_FLASH || mode == M_RESET))
        |-> $past(mode) == M_NORMAL);

    a_r9_reset_expires: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RESET && cnt == CNT_LAST && !grant.grant) |=> mode == M_INIT);

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST);

endmodule

// File: rtl/secmode_unlock.sv
module secmode_unlock
    import secmode_pkg::*;
#(
    parameter int                RESET_HOLD = 16,
    parameter logic [DATA_W-1:0] LFSR_SEED  = 8'h5A,
    parameter logic [DATA_W-1:0] LFSR_TAPS  = 8'hB8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        mode_o,
    output logic              mode_chg
);

    cmd_t              cmd;
    logic [DATA_W-1:0] rnd_now, rnd_nxt, code;
    logic              pending, changing;
    grant_t            grant;
    mode_e             mode;

    always_comb begin
        cmd.valid = cmd_valid;
        cmd.write = cmd_write;
        cmd.addr  = cmd_addr;
        cmd.data  = cmd_wdata;
    end

    secmode_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .state     (rnd_now),
        .state_nxt (rnd_nxt)
    );

    secmode_challenge u_chal (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .cur_mode      (mode),
        .mode_changing (changing),
        .rnd_now       (rnd_now),
        .rnd_nxt       (rnd_nxt),
        .code          (code),
        .pending       (pending),
        .grant         (grant)
    );

    secmode_fsm #(.RESET_HOLD(RESET_HOLD)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .grant    (grant),
        .mode     (mode),
        .mode_chg (mode_chg),
        .changing (changing)
    );

    assign mode_o = mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (cmd_valid && !cmd_write) begin
            case (cmd_addr)
                A_MODE:  rd_data <= {pending, 4'b0000, mode};
                A_CODE:  rd_data <= code;
                default: rd_data <= '0;
            endcase
        end
    end

    a_r4_read_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write && mode != M_RESET) |=> (!mode_chg && mode_o == $past(mode_o)));

    a_r8_idle_key_inert: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_addr == A_KEY && !pending && mode != M_RESET)
        |=> !mode_chg);

endmodule

// File: tb/secmode_unlock_test.sv
module secmode_unlock_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_write;
    logic [1:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic [7:0] rd_data;
    logic [2:0] mode_o;
    logic       mode_chg;

    int vectors = 0;
    int errs    = 0;

    // bench model
    int         m_mode;
    bit         m_pend;
    int         m_tgt;
    logic [7:0] m_code;

    secmode_unlock #(.RESET_HOLD(HOLD)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .mode_o(mode_o), .mode_chg(mode_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    function automatic bit legal(input int cur, input int tgt);
        if (tgt >= 1 && tgt <= 3) return cur == 0;
        if (tgt == 4) return cur != 4;
        return 1'b0;
    endfunction

    // starts and ends on a falling edge
    task automatic do_cmd(input bit w, input logic [1:0] a, input logic [7:0] d, output bit chg);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0;
        chg = mode_chg;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bit c;
        do_cmd(1'b0, a, 8'h00, c);
        d = rd_data;
    endtask

    task automatic check_state(input string tag);
        logic [7:0] v;
        check({tag, " mode"}, mode_o, m_mode);
        rd(2'd0, v);
        check({tag, " modereg"}, v, {m_pend, 4'b0, 3'(m_mode)});
        rd(2'd3, v);
        check({tag, " code"}, v, m_code);
    endtask

    task automatic reset_wait();
        // R9: entered Reset on the previous edge
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk);
        check("R9 still reset", mode_o, 3);
        check("R9 no early pulse", mode_chg, 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 back to init", mode_o, 4);
        check("R9 pulse", mode_chg, 1);
        m_mode = 4; m_pend = 0;
    endtask

    task automatic do_req(input int tgt);
        bit c;
        logic [7:0] v;
        do_cmd(1'b1, 2'd1, 8'(tgt), c);
        check("R3 req no change", c, 0);
        rd(2'd3, v);
        if (legal(m_mode, tgt)) begin
            check("R10 code nonzero", v != 0, 1);
            check("R5 code fresh", v != m_code, 1);
            m_pend = 1; m_tgt = tgt; m_code = v;
        end else begin
            check("R3 illegal code kept", v, m_code);
        end
        rd(2'd0, v);
        check("R3 pending flag", v, {m_pend, 4'b0, 3'(m_mode)});
    endtask

    task automatic do_key(input logic [7:0] k);
        bit c;
        bit ok;
        ok = m_pend && (k == ~m_code);
        do_cmd(1'b1, 2'd2, k, c);
        if (ok) begin
            check("R6 mode applied", mode_o, m_tgt);
            check("R6 pulse", c, 1);
            m_mode = m_tgt;
        end else begin
            check(m_pend ? "R7 wrong key mode" : "R8 idle key mode", mode_o, m_mode);
            check(m_pend ? "R7 wrong key pulse" : "R8 idle key pulse", c, 0);
        end
        m_pend = 0;
        if (m_mode == 3) reset_wait();
    endtask

    task automatic do_plain(input logic [7:0] d);
        bit c;
        bit ok;
        ok = (d == 0) && (m_mode == 4 || m_mode == 1 || m_mode == 2);
        do_cmd(1'b1, 2'd0, d, c);
        if (ok) begin m_mode = 0; m_pend = 0; end
        check("R2 plain mode", mode_o, m_mode);
        check("R2 plain pulse", c, ok);
    endtask

    initial begin
        logic [7:0] v, old;
        bit c;
        void'($urandom(32'd20240611));
        rst = 1'b1; cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mode = 4; m_pend = 0; m_tgt = 4; m_code = 0;

        // R1 reset state
        check("R1 mode", mode_o, 4);
        check("R1 chg", mode_chg, 0);
        check("R1 rd_data", rd_data, 0);
        check_state("R1");

        // R2: nonzero write ignored, then Init -> Normal
        do_plain(8'h05);
        do_plain(8'h00);
        do_plain(8'h00);           // from Normal: ignored

        // R6: Normal -> Interrupt
        do_req(1);
        do_key(~m_code);
        check_state("R4 after intr");
        do_plain(8'h00);

        // R7: wrong key cancels; later correct key ignored
        do_req(2);
        old = m_code;
        do_key(~m_code ^ 8'h10);
        do_key(~old);
        check_state("R7 after cancel");

        // R8: key with nothing pending
        do_key(8'hFF);

        // R3: illegal targets and illegal starting mode
        do_req(0); do_req(5); do_req(7);
        do_req(2);                 // legal
        do_req(6);                 // ignored, pending retained
        do_key(~m_code);           // Flash
        do_req(1);                 // illegal outside Normal
        do_req(4);                 // back to Init, secured
        do_key(~m_code);
        check("R3 init reached", mode_o, 4);
        do_plain(8'h00);

        // R11: replacement request
        do_req(1);
        old = m_code;
        do_req(2);
        check("R11 new code", m_code != old, 1);
        do_key(~old);
        check("R11 old key rejected", mode_o, 0);

        // R9: Reset and self-return
        do_req(3);
        do_key(~m_code);
        check_state("R9 after reset");
        do_plain(8'h00);

        // random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0: do_req((m_mode == 0 && ($urandom % 2)) ? 1 + ($urandom % 4) : $urandom % 8);
                1: do_key(~m_code);
                2: do_key(~m_code ^ 8'(1 + ($urandom % 255)));
                3: do_plain(($urandom % 3 == 0) ? 8'(1 + ($urandom % 255)) : 8'h00);
                4: begin
                    rd(2'd0, v);
                    check("R4 modereg", v, {m_pend, 4'b0, 3'(m_mode)});
                end
                default: begin
                    rd(2'd3, v);
                    check("R4 code readback", v, m_code);
                    do_cmd(1'b0, 2'd1, 8'h00, c);
                    check("R4 read no pulse", c, 0);
                end
            endcase
        end
        check_state("R4 final");
        finish_run();
    end

endmodule